// File: doc/BRIEF.md
# Multi-core interrupt router

This block gathers level-type interrupt sources and steers each one to a chosen core and to one of four parent interrupt lines on that core. Each source has an enable bit and a raw pending bit. Each source also has a routing target core, and each group of 32 sources has a pin-select byte. Every core keeps a routed-pending set that software clears by writing 1s. The block drives one parent line for each (core, pin) pair. A parent line changes only when the routed set behind it goes from empty to non-empty or back.

Source level changes arrive as events on a valid/ready stream. Configuration arrives on a word-wide write port with byte strobes, which is also valid/ready. The block applies at most one source update per clock. A write that needs several updates, such as an enable change, a pending clear or a re-route, is worked off by a sequencer, one source per cycle, lowest source first. While the sequencer is busy both streams are held off. An event is also held off in any cycle where a write is offered, so writes take priority. A producer keeps its valid and payload steady until ready is seen high at a clock edge.

With the defaults there are 64 sources and 4 cores. Word addresses are as follows:
- 0: configuration.
- 1: pin-select bytes. Byte g serves sources 32g to 32g+31.
- 2 and 3: enable words. Word 2+h covers sources 32h to 32h+31, bit i is source 32h+i.
- 4 to 19: core-select bytes. Address 4+w, byte k, is source 4w+k.
- 20 to 27: routed-pending clear. Core c, half h sits at 20+2c+h.

Top module: `irq_router`

## Requirements
- R1: An event with level 1 always sets the source's raw pending bit. An event with level 0 always clears it. An event is accepted on a clock edge where ev_valid and ev_ready are both high. ev_ready is low while the sequencer is busy or while wr_valid is high.
- R2: An accepted assertion of a source whose enable bit is 1 adds the source to the routed set of its target core. The line for that core and pin rises on the same edge if its group was empty. In every other case the lines hold their value. The line for core c, pin p is par_irq[4c+p].
- R3: An accepted deassertion removes the source from the routed set of its target core, whatever its enable bit. The line falls only if no other source of that core and pin is still in the set.
- R4: Configuration bit 1 selects the pin mode. When bit 1 is 0, the pin is the index of the lowest set bit of the pin-select byte. An all-zero byte or an index above 3 gives pin 0. When bit 1 is 1, bits 1:0 of the byte give the pin.
- R5: Configuration bit 2 selects the core mode for core-select writes. When bit 2 is 0, the core is the index of the lowest set bit of the byte, and an index of 4 or more gives core 0. When bit 2 is 1, the byte value is the core. An all-zero byte in the first mode, or a value of 4 or more in the second, leaves that source's routing unchanged. Only bytes whose strobe is set are decoded.
- R6: A write to an enable word re-evaluates every source whose bit changed and whose raw pending bit is set. The sources are taken one per cycle from the lowest bit. A newly enabled source acts as an assertion and a newly disabled source acts as a deassertion.
- R7: Writing 1s to a clear word removes those sources from that core's routed set. Each source that was actually in the set is processed as a deassertion for that core. Bits that were clear, and clear words of other cores, have no effect.
- R8: A core-select change that retargets a source with raw pending set first deasserts the source at the old core. On the next cycle it asserts the source at the new core. Routing changes only while the sequencer is busy.
- R9: A pin-select write does not move sources that are already in a routed set. No parent line changes because of it.
- R10: A configuration write takes effect only when the stored bit 0 is clear or the written value is zero. The stored value is the written bits 2:0 ANDed with the FEATURES parameter.
- R11: The block performs at most one source update per clock. wr_ready is low from the cycle after a multi-update write is accepted until its last update is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Source event offered |
| ev_ready | output | 1 | Event accepted at this edge if valid |
| ev_src | input | 6 | Source number of the event |
| ev_level | input | 1 | New level of the source |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Write accepted at this edge if valid |
| wr_addr | input | 5 | Word address |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes |
| par_irq | output | 16 | Parent lines, bit 4c+p for core c, pin p |

## Verification
The bench targets three cases. First, a line must not fall while another source of the same core and pin is still pending; a design that tracked only the last source would drop it early. Second, a source must move cleanly between cores during a live re-route, and an all-zero or out-of-range core byte must be ignored; a wrong design would leave a line stuck on the old core or send the source to core 0. Third, it checks the one-hot decode fall-backs, the refused configuration write while bit 0 is set, pin-select writes that must not move pending sources, clear writes to bits that are not set, and the write-port stall while an enable change is worked off.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int GRP  = 32;  // sources per enable word and per pin byte
  localparam int NPIN = 4;   // parent lines per core
  localparam int PW   = 2;   // width of a pin index

  localparam int CFG_ON       = 0;
  localparam int CFG_PIN_ENC  = 1;
  localparam int CFG_CORE_ENC = 2;

  localparam int A_CFG = 0;
  localparam int A_PIN = 1;
  localparam int A_EN  = 2;

  typedef enum logic [1:0] {
    JOB_ENA = 2'd0,
    JOB_CLR = 2'd1,
    JOB_MAP = 2'd2
  } job_e;
endpackage

// File: rtl/irq_lowbit.sv
module irq_lowbit #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_sel_dec.sv
// Turns a selector byte into a target index, one-hot or encoded.
module irq_sel_dec #(
  parameter int LIMIT  = 4,
  parameter bit IS_PIN = 1'b1,
  localparam int IW = $clog2(LIMIT)
) (
  input  logic [7:0]    sel,
  input  logic          enc,
  output logic [IW-1:0] idx,
  output logic          ok
);
  logic [2:0] lb;
  logic       any;

  irq_lowbit #(.W(8)) u_lb (.vec(sel), .idx(lb), .any(any));

  always_comb begin
    idx = '0;
    ok  = 1'b1;
    if (enc) begin
      idx = sel[IW-1:0];
      if (!IS_PIN) ok = (32'(sel) < LIMIT);
    end else if (!any) begin
      ok = IS_PIN;
    end else if (32'(lb) < LIMIT) begin
      idx = lb[IW-1:0];
    end
  end
endmodule

// File: rtl/irq_seq.sv
// Works off a multi-source write one source update per cycle.
module irq_seq import irq_router_pkg::*; #(
  parameter int NSRC  = 64,
  parameter int NCORE = 4,
  localparam int SW = $clog2(NSRC),
  localparam int CW = $clog2(NCORE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  job_e              ld_kind,
  input  logic [GRP-1:0]    ld_mask,
  input  logic [SW-1:0]     ld_base,
  input  logic [CW-1:0]     ld_core,
  input  logic [4*CW-1:0]   ld_tgt,
  input  logic [NSRC-1:0]   raw,
  input  logic [NSRC-1:0]   en,
  input  logic [NSRC*CW-1:0] route,
  output logic              busy,
  output logic              op_v,
  output logic [SW-1:0]     op_src,
  output logic [CW-1:0]     op_core,
  output logic              op_lvl,
  output logic              rt_we,
  output logic [SW-1:0]     rt_src,
  output logic [CW-1:0]     rt_tgt
);
  job_e            kind_q;
  logic [GRP-1:0]  mask_q;
  logic [SW-1:0]   base_q;
  logic [CW-1:0]   core_q;
  logic [4*CW-1:0] tgt_q;
  logic            ph_q;

  logic [$clog2(GRP)-1:0] k;
  logic                   done;
  logic [CW-1:0]          tgt;

  irq_lowbit #(.W(GRP)) u_pick (.vec(mask_q), .idx(k), .any(busy));

  always_comb begin
    op_src  = base_q + SW'(k);
    tgt     = tgt_q[int'(k[1:0])*CW +: CW];
    op_v    = 1'b0;
    op_core = route[op_src*CW +: CW];
    op_lvl  = 1'b0;
    rt_we   = 1'b0;
    rt_src  = op_src;
    rt_tgt  = tgt;
    done    = 1'b1;
    if (busy) begin
      unique case (kind_q)
        JOB_ENA: begin
          op_v   = 1'b1;
          op_lvl = en[op_src];
        end
        JOB_CLR: begin
          op_v    = 1'b1;
          op_core = core_q;
        end
        default: begin
          if (raw[op_src] && !ph_q) begin
            op_v = 1'b1;
            done = 1'b0;
          end else begin
            rt_we = 1'b1;
            if (raw[op_src]) begin
              op_v    = 1'b1;
              op_core = tgt;
              op_lvl  = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= JOB_ENA;
      mask_q <= '0;
      base_q <= '0;
      core_q <= '0;
      tgt_q  <= '0;
      ph_q   <= 1'b0;
    end else if (ld) begin
      kind_q <= ld_kind;
      mask_q <= ld_mask;
      base_q <= ld_base;
      core_q <= ld_core;
      tgt_q  <= ld_tgt;
      ph_q   <= 1'b0;
    end else if (busy) begin
      if (done) begin
        mask_q[k] <= 1'b0;
        ph_q      <= 1'b0;
      end else begin
        ph_q <= 1'b1;
      end
    end
  end

  assert_load_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !busy);

  assert_phase_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q |-> (kind_q == JOB_MAP && busy));
endmodule

// File: rtl/irq_router.sv
module irq_router import irq_router_pkg::*; #(
  parameter int         NSRC     = 64,
  parameter int         NCORE    = 4,
  parameter logic [2:0] FEATURES = 3'b111,
  localparam int SW    = $clog2(NSRC),
  localparam int CW    = $clog2(NCORE),
  localparam int NWORD = NSRC / GRP,
  localparam int A_MAP = A_EN + NWORD,
  localparam int A_CLR = A_MAP + NSRC / 4,
  localparam int A_END = A_CLR + NCORE * NWORD,
  localparam int AW    = $clog2(A_END),
  localparam int NPB   = (NWORD < 4) ? NWORD : 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  output logic                  ev_ready,
  input  logic [SW-1:0]         ev_src,
  input  logic                  ev_level,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [AW-1:0]         wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [3:0]            wr_strb,
  output logic [NCORE*NPIN-1:0] par_irq
);
  logic [2:0]            cfg_q, cfg_d;
  logic [NWORD*8-1:0]    pin_q, pin_d;
  logic [NSRC-1:0]       en_q, en_d, raw_q, raw_d;
  logic [NSRC-1:0]       rp_q [NCORE];
  logic [NSRC-1:0]       rp_d [NCORE];
  logic [NSRC*CW-1:0]    route_q, route_d;
  logic [NCORE*NPIN-1:0] line_q, line_d;

  // pin decode per group, then per-pin membership masks
  logic [PW-1:0]   gpin [NWORD];
  logic [PW-1:0]   gpin_e [NWORD];
  logic [NWORD-1:0] pin_ok;
  logic [NSRC-1:0] pm [NPIN];

  for (genvar g = 0; g < NWORD; g++) begin : g_pin
    irq_sel_dec #(.LIMIT(NPIN), .IS_PIN(1'b1)) u_pin (
      .sel(pin_q[g*8 +: 8]), .enc(cfg_q[CFG_PIN_ENC]),
      .idx(gpin[g]), .ok(pin_ok[g]));
    assign gpin_e[g] = pin_ok[g] ? gpin[g] : '0;
  end

  always_comb begin
    for (int p = 0; p < NPIN; p++)
      for (int s = 0; s < NSRC; s++)
        pm[p][s] = (gpin_e[s / GRP] == PW'(p));
  end

  // core decode of the four written bytes
  logic [CW-1:0]   ctgt [4];
  logic [3:0]      cok;
  logic [4*CW-1:0] ctgt_flat;

  for (genvar k = 0; k < 4; k++) begin : g_core
    irq_sel_dec #(.LIMIT(NCORE), .IS_PIN(1'b0)) u_core (
      .sel(wr_data[k*8 +: 8]), .enc(cfg_q[CFG_CORE_ENC]),
      .idx(ctgt[k]), .ok(cok[k]));
    assign ctgt_flat[k*CW +: CW] = ctgt[k];
  end

  // sequencer
  logic            ld, s_busy, s_op_v, s_op_lvl, s_rt_we;
  job_e            ld_kind;
  logic [GRP-1:0]  ld_mask;
  logic [SW-1:0]   ld_base, s_op_src, s_rt_src;
  logic [CW-1:0]   ld_core, s_op_core, s_rt_tgt;

  irq_seq #(.NSRC(NSRC), .NCORE(NCORE)) u_seq (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_kind(ld_kind), .ld_mask(ld_mask),
    .ld_base(ld_base), .ld_core(ld_core), .ld_tgt(ctgt_flat),
    .raw(raw_q), .en(en_q), .route(route_q), .busy(s_busy),
    .op_v(s_op_v), .op_src(s_op_src), .op_core(s_op_core), .op_lvl(s_op_lvl),
    .rt_we(s_rt_we), .rt_src(s_rt_src), .rt_tgt(s_rt_tgt));

  logic wr_fire, ev_fire;
  assign wr_ready = !s_busy;
  assign ev_ready = !s_busy && !wr_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign ev_fire  = ev_valid && ev_ready;

  // register writes and job launch
  always_comb begin
    logic [31:0] bm, nw;
    int a, h, c, w;
    bm      = {{8{wr_strb[3]}}, {8{wr_strb[2]}}, {8{wr_strb[1]}}, {8{wr_strb[0]}}};
    nw      = '0;
    a       = int'(wr_addr);
    h       = 0;
    c       = 0;
    w       = 0;
    ld      = 1'b0;
    ld_kind = JOB_ENA;
    ld_mask = '0;
    ld_base = '0;
    ld_core = '0;
    cfg_d   = cfg_q;
    pin_d   = pin_q;
    en_d    = en_q;
    if (wr_fire) begin
      if (a == A_CFG) begin
        if (!cfg_q[CFG_ON] || wr_data == '0) cfg_d = wr_data[2:0] & FEATURES;
      end else if (a == A_PIN) begin
        for (int b = 0; b < NPB; b++)
          if (wr_strb[b]) pin_d[b*8 +: 8] = wr_data[b*8 +: 8];
      end else if (a >= A_EN && a < A_MAP) begin
        h  = a - A_EN;
        nw = (en_q[h*GRP +: GRP] & ~bm) | (wr_data & bm);
        en_d[h*GRP +: GRP] = nw;
        ld_mask = (nw ^ en_q[h*GRP +: GRP]) & raw_q[h*GRP +: GRP];
        ld_base = SW'(h * GRP);
        ld      = |ld_mask;
      end else if (a >= A_MAP && a < A_CLR) begin
        w = a - A_MAP;
        for (int k = 0; k < 4; k++)
          ld_mask[k] = wr_strb[k] && cok[k] && (ctgt[k] != route_q[(w*4+k)*CW +: CW]);
        ld_kind = JOB_MAP;
        ld_base = SW'(w * 4);
        ld      = |ld_mask;
      end else if (a >= A_CLR && a < A_END) begin
        c = (a - A_CLR) / NWORD;
        h = (a - A_CLR) % NWORD;
        ld_mask = wr_data & bm & rp_q[c][h*GRP +: GRP];
        ld_kind = JOB_CLR;
        ld_base = SW'(h * GRP);
        ld_core = CW'(c);
        ld      = |ld_mask;
      end
    end
  end

  // one source update per cycle
  logic          op_v, op_lvl;
  logic [SW-1:0] op_src;
  logic [CW-1:0] op_core;

  assign op_v    = ev_fire || s_op_v;
  assign op_src  = ev_fire ? ev_src : s_op_src;
  assign op_core = ev_fire ? route_q[ev_src*CW +: CW] : s_op_core;
  assign op_lvl  = ev_fire ? ev_level : s_op_lvl;

  always_comb begin
    logic [NSRC-1:0] grp;
    int p;
    rp_d    = rp_q;
    line_d  = line_q;
    route_d = route_q;
    raw_d   = raw_q;
    if (ev_fire) raw_d[ev_src] = ev_level;
    if (s_rt_we) route_d[s_rt_src*CW +: CW] = s_rt_tgt;
    p   = int'(gpin_e[int'(op_src) / GRP]);
    grp = rp_q[op_core] & pm[p];
    if (op_v) begin
      if (op_lvl) begin
        if (en_q[op_src]) begin
          rp_d[op_core][op_src] = 1'b1;
          if (grp == '0) line_d[int'(op_core)*NPIN + p] = 1'b1;
        end
      end else begin
        rp_d[op_core][op_src] = 1'b0;
        if ((grp & ~(NSRC'(1) << op_src)) == '0) line_d[int'(op_core)*NPIN + p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      pin_q   <= '0;
      en_q    <= '0;
      raw_q   <= '0;
      route_q <= '0;
      line_q  <= '0;
      for (int c = 0; c < NCORE; c++) rp_q[c] <= '0;
    end else begin
      cfg_q   <= cfg_d;
      pin_q   <= pin_d;
      en_q    <= en_d;
      raw_q   <= raw_d;
      route_q <= route_d;
      line_q  <= line_d;
      rp_q    <= rp_d;
    end
  end

  assign par_irq = line_q;

  logic [NSRC-1:0] rp_any;
  always_comb begin
    rp_any = '0;
    for (int c = 0; c < NCORE; c++) rp_any = rp_any | rp_q[c];
  end

  assert_raw_cover_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_any & ~raw_q) == '0);

  assert_line_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_v |=> $stable(line_q));

  assert_cfg_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[CFG_ON] |=> (cfg_q == $past(cfg_q)) || (cfg_q == '0));

  assert_route_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s_busy |=> $stable(route_q));

  assert_one_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_fire, s_op_v}));
endmodule

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [5:0]  ev_src = '0;
  logic        ev_level = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic [15:0] par_irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  bit busy_seen;

  always #2.5 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_level(ev_level), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .par_irq(par_irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 5'(a); wr_data = d; wr_strb = s;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    busy_seen = !wr_ready;
    while (!wr_ready) @(negedge clk);
  endtask

  task automatic ev(input int src, input logic lvl);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = 6'(src); ev_level = lvl;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic t_raw_then_enable();
    ev(3, 1);
    check("R1 raw set while disabled", par_irq, 16'h0000);
    wr(2, 32'h8, 4'hF);
    check("R6 enable of raw source", par_irq, 16'h0001);
  endtask

  task automatic t_shared_line();
    wr(2, 32'h28, 4'hF);
    ev(5, 1);
    check("R2 second source keeps line", par_irq, 16'h0001);
    ev(3, 0);
    check("R3 line held by other source", par_irq, 16'h0001);
    ev(5, 0);
    check("R3 last source clears line", par_irq, 16'h0000);
  endtask

  task automatic t_pin_decode();
    wr(1, 32'h04, 4'h1);
    ev(5, 1);
    check("R4 one-hot pin 2", par_irq, 16'h0004);
    ev(5, 0);
    wr(1, 32'h80, 4'h1);
    ev(5, 1);
    check("R4 high bit falls back to pin 0", par_irq, 16'h0001);
    ev(5, 0);
    wr(0, 32'h2, 4'hF);
    wr(1, 32'h03, 4'h1);
    ev(5, 1);
    check("R4 encoded pin 3", par_irq, 16'h0008);
    ev(5, 0);
    wr(0, 32'h0, 4'hF);
  endtask

  task automatic t_core_route();
    wr(1, 32'h00, 4'h1);
    wr(5, 32'h0400, 4'h2);
    ev(5, 1);
    check("R5 one-hot core 2", par_irq, 16'h0100);
    wr(5, 32'h0200, 4'h2);
    check("R8 live move to core 1", par_irq, 16'h0010);
    wr(5, 32'h0000, 4'h2);
    check("R5 zero byte keeps route", par_irq, 16'h0010);
    wr(5, 32'h1000, 4'h2);
    check("R5 index 4 falls back to core 0", par_irq, 16'h0001);
    wr(0, 32'h4, 4'hF);
    wr(5, 32'h0700, 4'h2);
    check("R5 encoded out of range ignored", par_irq, 16'h0001);
    wr(5, 32'h0300, 4'h2);
    check("R8 encoded move to core 3", par_irq, 16'h1000);
    wr(0, 32'h0, 4'hF);
    ev(5, 0);
  endtask

  task automatic t_pin_no_move();
    wr(1, 32'h01, 4'h1);
    ev(5, 1);
    wr(1, 32'h02, 4'h1);
    check("R9 pin write leaves line", par_irq, 16'h1000);
    wr(1, 32'h01, 4'h1);
    ev(5, 0);
    check("R3 cleanup", par_irq, 16'h0000);
  endtask

  task automatic t_clear();
    wr(3, 32'h2, 4'hF);
    ev(3, 1);
    ev(33, 1);
    check("R2 two sources on core 0", par_irq, 16'h0001);
    wr(22, 32'h8, 4'hF);
    check("R7 clear on other core ignored", par_irq, 16'h0001);
    wr(20, 32'h8, 4'hF);
    check("R7 clear one of two", par_irq, 16'h0001);
    wr(21, 32'h2, 4'hF);
    check("R7 clear last drops line", par_irq, 16'h0000);
    ev(3, 0);
    ev(33, 0);
  endtask

  task automatic t_disable();
    ev(5, 1);
    wr(2, 32'h08, 4'hF);
    check("R6 disable deasserts", par_irq, 16'h0000);
    wr(2, 32'h28, 4'hF);
    check("R6 re-enable asserts", par_irq, 16'h1000);
    ev(5, 0);
  endtask

  task automatic t_stall();
    wr(2, 32'h0, 4'hF);
    ev(3, 1);
    ev(5, 1);
    check("R1 raw only while disabled", par_irq, 16'h0000);
    wr(2, 32'h28, 4'hF);
    check("R11 stall after multi-update write", 16'(busy_seen), 16'h0001);
    check("R6 two sources enabled", par_irq, 16'h1001);
    ev(3, 0);
    ev(5, 0);
  endtask

  task automatic t_cfg_lock();
    wr(1, 32'h03, 4'h1);
    wr(0, 32'h1, 4'hF);
    wr(0, 32'h2, 4'hF);
    ev(5, 1);
    check("R10 locked write refused", par_irq, 16'h1000);
    ev(5, 0);
    wr(0, 32'h0, 4'hF);
    wr(0, 32'h2, 4'hF);
    ev(5, 1);
    check("R10 write after unlock", par_irq, 16'h8000);
    ev(5, 0);
    check("R3 final clear", par_irq, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset state", par_irq, 16'h0000);
    t_raw_then_enable();
    t_shared_line();
    t_pin_decode();
    t_core_route();
    t_pin_no_move();
    t_clear();
    t_disable();
    t_stall();
    t_cfg_lock();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end
endmodule